// File: doc/BRIEF.md
# Successive Approximation Conversion Controller

This block is the digital sequencer of an 8-bit successive-approximation analog-to-digital converter. It runs on a free-running conversion clock. When the sampled input is ready, the system raises a start level. The controller then sends a series of trial codes to an external digital-to-analog converter. A single comparator bit comes back, saying whether the trial is above or below the held input.

The controller settles one bit on each clock, starting at the most significant bit and working down. After the last bit it presents the code and raises an end-of-conversion flag. Both stay put until the system lowers start. A new conversion is accepted only after start has been seen low, so a start level that stays high cannot launch a second conversion.

The DAC, the comparator and the sample-and-hold stage are outside this block.

Top module: `sar_conv_ctrl`

## Requirements
- R1: A synchronous active-high reset `rst` sends the controller to idle. In idle, `eocFlag` is 0 and both `trialCode` and `resultCode` are 0.
- R2: A conversion is accepted only in idle, only with `startLvl` high, and only if `startLvl` has been sampled low since the last reset or since the last accepted conversion. If `startLvl` is already high when reset is released, nothing starts until it has gone low once.
- R3: On the clock after the accepting edge, `trialCode` shows mid-scale `8'b1000_0000`.
- R4: `cmpHigh` is sampled one clock after each trial code appears. Encoding: 1 means the trial is too high, 0 means it is too low. The bit under test is cleared when `cmpHigh`=1 and kept when `cmpHigh`=0. The next lower bit is then set for the following trial.
- R5: Exactly 8 decisions are taken, from bit 7 down to bit 0. `eocFlag` rises on the edge that samples the bit-0 decision, which is the 9th rising edge counting the accepting edge.
- R6: At that same edge, `resultCode` captures the final adjusted code. Example: the decisions keep, keep, revert, keep, keep, revert, keep, keep give `8'b1101_1011`. `resultCode` changes at no other time except reset.
- R7: `eocFlag` stays high while `startLvl` is high. It clears on the clock after `startLvl` is sampled low, and the controller then returns to idle.
- R8: If `startLvl` falls during a conversion, the conversion still completes with the correct code and timing. `eocFlag` is then high for exactly one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running conversion clock |
| rst | input | 1 | Synchronous active-high reset |
| startLvl | input | 1 | Start level; high while a conversion is requested |
| cmpHigh | input | 1 | Comparator result; 1 = trial above the input |
| eocFlag | output | 1 | End of conversion; `resultCode` is valid |
| resultCode | output | 8 | Final conversion code |
| trialCode | output | 8 | Trial code sent to the external DAC |

## Verification
The controller's hidden state is a bit index and a phase. A wrong index shows on `trialCode` at the very next clock: the wrong bit gets set or cleared, or the walk down the bits stops early. It also shows on when `eocFlag` rises. The bench models the DAC and comparator as a threshold and runs a cycle-accurate reference beside the design, so any mismatch in phase, armed state or code is caught on the clock where it first appears. Input levels at both ends of the range and at mid-scale test the edges of the binary search.

// File: rtl/sar_pkg.sv
`timescale 1ns/1ps
package sar_pkg;
  typedef enum logic [1:0] {
    stIdle = 2'd0,
    stConv = 2'd1,
    stDone = 2'd2
  } sarState_t;

  typedef struct packed {
    logic loadMid;
    logic resolve;
    logic capture;
  } sarStrobes_t;
endpackage

// File: rtl/sar_ctrl.sv
`timescale 1ns/1ps
module sar_ctrl
  import sar_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             startLvl,
  output sarStrobes_t      strobes,
  output logic [WIDTH-1:0] bitSel,
  output logic             eocFlag
);
  localparam int IW = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam logic [IW-1:0] TOP_IDX = IW'(WIDTH - 1);

  sarState_t     state;
  logic [IW-1:0] bitIdx;
  logic          armed;
  logic          accept;

  assign accept          = (state == stIdle) && startLvl && armed;
  assign strobes.loadMid = accept;
  assign strobes.resolve = (state == stConv);
  assign strobes.capture = (state == stConv) && (bitIdx == '0);
  assign bitSel          = (state == stConv) ? (WIDTH'(1) << bitIdx) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= stIdle;
      bitIdx  <= '0;
      armed   <= 1'b0;
      eocFlag <= 1'b0;
    end else begin
      if (!startLvl) armed <= 1'b1;
      else if (accept) armed <= 1'b0;
      case (state)
        stIdle: begin
          if (accept) begin
            state  <= stConv;
            bitIdx <= TOP_IDX;
          end
        end
        stConv: begin
          if (bitIdx == '0) begin
            state   <= stDone;
            eocFlag <= 1'b1;
          end else begin
            bitIdx <= bitIdx - 1'b1;
          end
        end
        stDone: begin
          if (!startLvl) begin
            state   <= stIdle;
            eocFlag <= 1'b0;
          end
        end
        default: state <= stIdle;
      endcase
    end
  end

  // R7
  eoc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    eocFlag && startLvl |=> eocFlag);
  // R7
  eoc_clear_chk: assert property (@(posedge clk) disable iff (rst)
    eocFlag && !startLvl |=> !eocFlag);
  // R5
  eoc_phase_chk: assert property (@(posedge clk) disable iff (rst)
    eocFlag |-> state == stDone);
  // R5
  eoc_last_bit_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(eocFlag) |-> $past(state) == stConv && $past(bitIdx) == '0);
  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (state == stIdle) && !startLvl |=> state == stIdle);
endmodule

// File: rtl/sar_datapath.sv
`timescale 1ns/1ps
module sar_datapath
  import sar_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  sarStrobes_t      strobes,
  input  logic [WIDTH-1:0] bitSel,
  input  logic             cmpHigh,
  output logic [WIDTH-1:0] trialCode,
  output logic [WIDTH-1:0] resultCode
);
  localparam logic [WIDTH-1:0] MID_CODE = {1'b1, {(WIDTH-1){1'b0}}};

  logic [WIDTH-1:0] keptCode;
  logic [WIDTH-1:0] nextTrial;

  assign keptCode  = cmpHigh ? (trialCode & ~bitSel) : trialCode;
  assign nextTrial = keptCode | (bitSel >> 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      trialCode  <= '0;
      resultCode <= '0;
    end else begin
      if (strobes.loadMid)      trialCode <= MID_CODE;
      else if (strobes.resolve) trialCode <= nextTrial;
      if (strobes.capture)      resultCode <= keptCode;
    end
  end

  // R3
  mid_load_chk: assert property (@(posedge clk) disable iff (rst)
    strobes.loadMid |=> trialCode == MID_CODE);
  // R4
  over_drop_chk: assert property (@(posedge clk) disable iff (rst)
    strobes.resolve && cmpHigh |=> trialCode < $past(trialCode));
  // R4
  under_keep_chk: assert property (@(posedge clk) disable iff (rst)
    strobes.resolve && !cmpHigh |=> trialCode >= $past(trialCode));
  // R6
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !strobes.capture |=> $stable(resultCode));
endmodule

// File: rtl/sar_conv_ctrl.sv
`timescale 1ns/1ps
module sar_conv_ctrl
  import sar_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             startLvl,
  input  logic             cmpHigh,
  output logic             eocFlag,
  output logic [WIDTH-1:0] resultCode,
  output logic [WIDTH-1:0] trialCode
);
  sarStrobes_t      strobes;
  logic [WIDTH-1:0] bitSel;

  sar_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .startLvl (startLvl),
    .strobes  (strobes),
    .bitSel   (bitSel),
    .eocFlag  (eocFlag)
  );

  sar_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk        (clk),
    .rst        (rst),
    .strobes    (strobes),
    .bitSel     (bitSel),
    .cmpHigh    (cmpHigh),
    .trialCode  (trialCode),
    .resultCode (resultCode)
  );

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    $past(rst) |-> !eocFlag && trialCode == '0 && resultCode == '0);
endmodule

// File: tb/sar_conv_ctrl_test.sv
`timescale 1ns/1ps
module sar_conv_ctrl_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic startLvl = 1'b0;
  logic cmpHigh;
  logic eocFlag;
  logic [7:0] resultCode, trialCode;
  int vin = 0;
  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit tracking = 1'b0;

  always #2.5 clk = ~clk;

  // behavioural DAC + comparator: trial above the held level -> 1
  assign cmpHigh = (int'(trialCode) > vin);

  sar_conv_ctrl uut (
    .clk(clk), .rst(rst), .startLvl(startLvl), .cmpHigh(cmpHigh),
    .eocFlag(eocFlag), .resultCode(resultCode), .trialCode(trialCode)
  );

  // reference model: phase 0 idle, 1 converting, 2 done
  int mPhase = 0, mTrial = 0, mResult = 0, mIdx = 0;
  bit mEoc = 0, mArmed = 0;

  always @(posedge clk) begin
    if (rst) begin
      mPhase = 0; mTrial = 0; mResult = 0; mEoc = 0; mArmed = 0; mIdx = 0;
    end else begin
      bit wasArmed;
      wasArmed = mArmed;
      if (!startLvl) mArmed = 1;
      if (mPhase == 0) begin
        if (startLvl && wasArmed) begin
          mPhase = 1; mTrial = 128; mIdx = 7; mArmed = 0;
        end
      end else if (mPhase == 1) begin
        int t;
        t = (mTrial > vin) ? mTrial - (1 << mIdx) : mTrial;
        if (mIdx == 0) begin
          mTrial = t; mResult = t; mEoc = 1; mPhase = 2;
        end else begin
          mTrial = t + (1 << (mIdx - 1)); mIdx = mIdx - 1;
        end
      end else begin
        if (!startLvl) begin
          mEoc = 0; mPhase = 0;
        end
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (tracking && !rst) begin
      check(int'(trialCode) == mTrial, "R4 trialCode vs model", trialCode, mTrial);
      check(int'(resultCode) == mResult, "R6 resultCode vs model", resultCode, mResult);
      check(eocFlag == mEoc, "R7 eocFlag vs model", eocFlag, mEoc);
    end
    if (cycles > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired act=%0d exp=%0d", cycles, 100000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic convert(input int level, input int dropAt);
    int k;
    vin = level;
    @(negedge clk);
    startLvl = 1'b1;
    k = 0;
    while (!eocFlag && k < 20) begin
      @(negedge clk);
      k++;
      if (k == 1) check(trialCode == 8'h80, "R3 first trial mid-scale", trialCode, 128);
      if (k == dropAt) startLvl = 1'b0;
    end
    check(k == 9, "R5 eoc on ninth edge", k, 9);
    check(int'(resultCode) == level, "R6 final code", resultCode, level);
    if (dropAt > 0) begin
      @(negedge clk);
      check(eocFlag == 1'b0, "R8 eoc one clock after early drop", eocFlag, 0);
    end else begin
      repeat (3) @(negedge clk);
      check(eocFlag == 1'b1, "R7 eoc held while start high", eocFlag, 1);
      check(int'(resultCode) == level, "R6 result held", resultCode, level);
      startLvl = 1'b0;
      @(negedge clk);
      check(eocFlag == 1'b0, "R7 eoc cleared after start low", eocFlag, 0);
      check(int'(resultCode) == level, "R6 result kept after eoc", resultCode, level);
    end
    @(negedge clk);
  endtask

  initial begin
    startLvl = 1'b1;
    repeat (3) @(negedge clk);
    check(eocFlag == 1'b0, "R1 reset eoc", eocFlag, 0);
    check(trialCode == 8'h00, "R1 reset trial", trialCode, 0);
    check(resultCode == 8'h00, "R1 reset result", resultCode, 0);
    rst = 1'b0;
    tracking = 1'b1;
    repeat (12) @(negedge clk);
    check(trialCode == 8'h00, "R2 no start while unarmed", trialCode, 0);
    check(eocFlag == 1'b0, "R2 no eoc while unarmed", eocFlag, 0);
    startLvl = 1'b0;
    @(negedge clk);

    convert(8'hDB, 0);
    convert(0, 0);
    convert(255, 0);
    convert(8'h80, 0);
    convert(8'h7F, 0);
    convert(8'h55, 0);
    convert(8'h3C, 4);
    convert(8'hA1, 1);

    // reset mid-conversion, start left high
    vin = 8'h66;
    startLvl = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check(trialCode == 8'h00, "R1 reset mid-run trial", trialCode, 0);
    check(resultCode == 8'h00, "R1 reset mid-run result", resultCode, 0);
    check(eocFlag == 1'b0, "R1 reset mid-run eoc", eocFlag, 0);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    check(trialCode == 8'h00, "R2 held start after reset ignored", trialCode, 0);
    startLvl = 1'b0;
    @(negedge clk);
    convert(8'h66, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule